// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

A memory-mapped real-time clock for a simple 32-bit register bus with single-cycle read and write strobes. A prescaler divides the system clock down to one pulse per second, and each pulse advances a free-running 32-bit seconds count that wraps modulo 2^32. Software can overwrite the count at any time, and can program an alarm value. When the count reaches the alarm value the block latches a raw alarm flag. A one-bit enable gates that flag onto the interrupt pin.

The register window spans 4 KiB. The low offsets hold the count, alarm, load, control and interrupt registers. The top 32 bytes return eight fixed identification bytes, one per word. The control register exists only for compatibility: it always reports the clock as running.

Top module: `sec_rtc`

## Requirements
- R1: The count rises by exactly one every CLKS_PER_SEC clock cycles and wraps from 0xFFFFFFFF to 0x00000000; it is read at offset 0x00.
- R2: A write to offset 0x08 sets the count to the written value on the next edge and restarts the prescaler, so the next increment comes a full CLKS_PER_SEC cycles later; reading 0x08 returns the last value written there.
- R3: Offset 0x04 holds the alarm value and reads it back; the raw flag (offset 0x14, bit 0) sets on the edge where an increment makes the count equal the alarm value, including when the alarm is numerically below the count and is reached after the wrap.
- R4: A write to 0x04 or 0x08 that leaves the alarm value equal to the count sets the raw flag on that same edge.
- R5: A write to offset 0x10 keeps only data bit 0 as the interrupt enable, and reading 0x10 returns that single bit.
- R6: Offset 0x18 reads raw flag AND enable, and the irq pin carries that same value.
- R7: A write of any data to offset 0x1C clears the raw flag; when an alarm event falls on the same edge, the flag stays set.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: Reads of offsets 0xFE0, 0xFE4, ... 0xFFC return 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R10: Reads of 0x1C and of undefined offsets return zero; writes to 0x00, 0x14, 0x18 and undefined offsets have no effect.
- R11: Reset clears the count, the alarm value, the load value, the enable and the raw flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low |
| irq | output | 1 | Alarm interrupt, raw flag AND enable |

## Verification
The bench goes after the alarm on the far side of the 32-bit wrap. A design that compares magnitudes instead of testing equality would fire early or never there. It checks the prescaler restart after a load, where a design that keeps the old phase shows the new count advancing too soon. It puts a clear write on the very edge where an alarm arrives; letting the clear win would lose that alarm. It also covers the immediate alarm on a match or load write, where a design that looks only at ticks would miss the event until the count next wraps. It also checks that writes to read-only offsets and upper mask bits leave no trace.

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int CLKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_SEC - 1);

  localparam logic [11:0] A_COUNT = 12'h000;
  localparam logic [11:0] A_ALARM = 12'h004;
  localparam logic [11:0] A_LOAD  = 12'h008;
  localparam logic [11:0] A_CTRL  = 12'h00C;
  localparam logic [11:0] A_EN    = 12'h010;
  localparam logic [11:0] A_RAW   = 12'h014;
  localparam logic [11:0] A_MASKD = 12'h018;
  localparam logic [11:0] A_CLR   = 12'h01C;

  logic [PW-1:0] pre;
  logic [31:0]   cnt, alarm, load_val;
  logic          en, raw;

  logic          tick, w_alarm, w_load, w_en, w_clr, alarm_evt;
  logic [31:0]   cnt_nxt, alarm_nxt;

  assign tick    = (pre == PRE_LAST);
  assign w_alarm = wr_en && addr == A_ALARM;
  assign w_load  = wr_en && addr == A_LOAD;
  assign w_en    = wr_en && addr == A_EN;
  assign w_clr   = wr_en && addr == A_CLR;

  assign cnt_nxt   = w_load ? wdata : (tick ? cnt + 32'd1 : cnt);
  assign alarm_nxt = w_alarm ? wdata : alarm;
  assign alarm_evt = (cnt_nxt == alarm_nxt) && (tick || w_load || w_alarm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre      <= '0;
      cnt      <= '0;
      alarm    <= '0;
      load_val <= '0;
      en       <= 1'b0;
      raw      <= 1'b0;
    end else begin
      pre   <= (w_load || tick) ? '0 : pre + 1'b1;
      cnt   <= cnt_nxt;
      alarm <= alarm_nxt;
      if (w_load) load_val <= wdata;
      if (w_en)   en <= wdata[0];
      if (alarm_evt)  raw <= 1'b1;
      else if (w_clr) raw <= 1'b0;
    end
  end

  assign irq = raw & en;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr[11:5] == 7'h7F && addr[1:0] == 2'b00)
        rdata = {24'd0, id_byte(addr[4:2])};
      else
        case (addr)
          A_COUNT: rdata = cnt;
          A_ALARM: rdata = alarm;
          A_LOAD:  rdata = load_val;
          A_CTRL:  rdata = 32'd1;
          A_EN:    rdata = {31'd0, en};
          A_RAW:   rdata = {31'd0, raw};
          A_MASKD: rdata = {31'd0, irq};
          default: rdata = '0;
        endcase
    end
  end

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !w_load) |=> cnt == $past(cnt) + 32'd1);

  assert_load_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |=> (cnt == $past(wdata) && load_val == $past(wdata)));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !w_clr) |=> raw);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_clr && !alarm_evt) |=> !raw);

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && raw));
endmodule

// File: tb/test_sec_rtc.sv
module test_sec_rtc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  sec_rtc #(.CLKS_PER_SEC(4)) i_sec_rtc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (rd_en && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, addr, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
    addr  = a;
    rd_en = 1;
    @(posedge clk);
    #1 rd_en = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(12'h000, 32'd0, "R11 count");
    rd(12'h004, 32'd0, "R11 alarm");
    rd(12'h008, 32'd0, "R11 load");
    rd(12'h010, 32'd0, "R11 enable");
    rd(12'h014, 32'd0, "R11 raw");
    chk_irq(1'b0, "R11 irq");

    rd(12'h00C, 32'd1, "R8 ctrl");
    wr(12'h00C, 32'd0);
    rd(12'h00C, 32'd1, "R8 ctrl after write");

    begin : ids
      logic [7:0] idv [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++)
        rd(12'hFE0 + 12'(i * 4), {24'd0, idv[i]}, "R9 id byte");
    end

    rd(12'h01C, 32'd0, "R10 clear reads zero");
    rd(12'h020, 32'd0, "R10 undefined reads zero");

    wr(12'h010, 32'hFFFF_FFFE);
    rd(12'h010, 32'd0, "R5 only bit0 kept");
    wr(12'h010, 32'd3);
    rd(12'h010, 32'd1, "R5 enable readback");
    wr(12'h010, 32'd0);

    wr(12'h008, 32'h1000);
    rd(12'h000, 32'h1000, "R2 load takes");
    wr(12'h000, 32'hDEAD);
    rd(12'h008, 32'h1000, "R2 load readback");
    rd(12'h000, 32'h1000, "R2 prescaler restarted");
    rd(12'h000, 32'h1001, "R1 first tick");
    idle(3);
    rd(12'h000, 32'h1002, "R1 second tick");

    wr(12'h004, 32'h1002);
    rd(12'h014, 32'd1, "R4 alarm write equals count");
    rd(12'h004, 32'h1002, "R3 alarm readback");
    chk_irq(1'b0, "R6 irq masked off");
    rd(12'h018, 32'd0, "R6 masked status off");
    wr(12'h010, 32'd1);
    chk_irq(1'b1, "R6 irq on");
    rd(12'h018, 32'd1, "R6 masked status on");

    wr(12'h01C, 32'd0);
    chk_irq(1'b0, "R7 irq after clear");
    rd(12'h014, 32'd0, "R7 clear with zero data");
    wr(12'h014, 32'd1);
    rd(12'h014, 32'd0, "R10 raw write ignored");

    wr(12'h008, 32'hFFFF_FFFE);
    wr(12'h004, 32'd1);
    idle(10);
    rd(12'h014, 32'd0, "R3 not yet at wrapped alarm");
    rd(12'h014, 32'd1, "R3 alarm after wrap");
    rd(12'h000, 32'd1, "R1 wrapped count");
    chk_irq(1'b1, "R6 irq after wrap alarm");

    wr(12'h01C, 32'h5A5A);
    wr(12'h004, 32'h500);
    wr(12'h008, 32'h500);
    rd(12'h014, 32'd1, "R4 load equals alarm");

    wr(12'h01C, 32'd0);
    wr(12'h004, 32'h2001);
    wr(12'h008, 32'h2000);
    idle(3);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h014, 32'd1, "R7 set beats clear");
    wr(12'h01C, 32'd1);
    rd(12'h014, 32'd0, "R7 later clear");

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule